// File: doc/BRIEF.md
# DMA Request Time-out Timer

This block watches one DMA channel. It measures how long the channel has been waiting for its next peripheral request. A 16-bit down-counter is loaded from a programmable reload value. While the timer is enabled, the counter decrements once per clock. Each time the channel finishes servicing a peripheral request, the counter is restarted from the reload value. The count therefore measures idle gaps between requests, not the length of the whole transfer.

When the counter runs out, a sticky time-out status flag is raised. Software clears the flag by writing 1, which reaches this block as a one-cycle clear pulse. The interrupt output is the flag gated by an interrupt enable.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `dma_req_timeout`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `tmo_flag` and `tmo_irq` are 0.
- R2: While `tmo_en` is 0, the counter does not count. One clock later, `count` equals the value present on `tmo_reload`.
- R3: With `tmo_en` at 1 and no service pulse, `count` decreases by exactly 1 on each rising edge, starting from the reload value. `tmo_flag` becomes 1 after the (R+1)-th rising edge with `tmo_en` high, where R is the reload value.
- R4: Once the counter reaches 0, it holds at 0 until a service pulse arrives or `tmo_en` goes low. One stay at 0 sets the flag only once, so a flag cleared while the count stays at 0 remains 0.
- R5: A `req_done` pulse while enabled reloads `count` from `tmo_reload` on the next edge.
- R6: If `req_done` arrives in the cycle in which the counter sits at 0, the reload wins and the flag is not set.
- R7: A reload value of 0 sets the flag on the first enabled rising edge.
- R8: A `flag_w1c` pulse clears `tmo_flag` on the next edge. If a time-out occurs in the same cycle, the flag is set instead.
- R9: Dropping `tmo_en` reloads the counter and leaves `tmo_flag` unchanged. With no time-out and no clear pulse, the flag holds its value.
- R10: `tmo_irq` is 1 exactly when `tmo_flag` is 1 and `irq_en` is 1, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmo_en | input | 1 | Timer enable |
| tmo_reload | input | 16 | Reload value for the countdown |
| req_done | input | 1 | One-cycle pulse: a peripheral request was serviced |
| flag_w1c | input | 1 | One-cycle pulse: software wrote 1 to the status flag |
| irq_en | input | 1 | Time-out interrupt enable |
| count | output | 16 | Current countdown value |
| tmo_flag | output | 1 | Sticky time-out status flag |
| tmo_irq | output | 1 | Gated time-out interrupt |

## Verification
The assertions assume that `req_done` and `flag_w1c` are one-cycle pulses. They also assume that `tmo_reload` is held steady while the timer counts, so that a reload taken after a service pulse or after disabling matches the value seen one cycle earlier. The bench applies every input change one time unit after a rising edge and keeps each pulse to a single cycle. It changes the reload value only while the timer is disabled. It then samples the outputs in that same quiet window, before it drives the next stimulus.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  // Action taken by the countdown register in the coming cycle
  typedef enum logic [1:0] {
    TMO_LOAD = 2'd0,
    TMO_DEC  = 2'd1,
    TMO_HOLD = 2'd2
  } tmo_act_e;
endpackage

// File: rtl/tmo_countdown.sv
module tmo_countdown #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             svc,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  import tmo_pkg::*;

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             loaded_q;  // counter holds a valid reload since reset
  logic             fired_q;   // expiry already reported for this stay at zero
  tmo_act_e         act;

  always_comb begin
    if (!loaded_q || !en || svc) act = TMO_LOAD;
    else if (cnt_q != CNT_ZERO)  act = TMO_DEC;
    else                         act = TMO_HOLD;
  end

  assign expire_o = loaded_q && en && !svc && (cnt_q == CNT_ZERO) && !fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= CNT_ZERO;
      loaded_q <= 1'b0;
      fired_q  <= 1'b0;
    end else begin
      loaded_q <= 1'b1;
      case (act)
        TMO_LOAD: cnt_q <= reload;
        TMO_DEC:  cnt_q <= cnt_q - CNT_ONE;
        default:  cnt_q <= cnt_q;
      endcase
      if (!en || svc)    fired_q <= 1'b0;
      else if (expire_o) fired_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // R2: disabled timer tracks the reload value
  assert_idle_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt_q == $past(reload));
  // R3: one step down per clock while running
  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && en && !svc && cnt_q != CNT_ZERO) |=> cnt_q == $past(cnt_q) - CNT_ONE);
  // R4: zero is held, no wrap
  assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && en && !svc && cnt_q == CNT_ZERO) |=> cnt_q == CNT_ZERO);
  // R4: a single expiry per stay at zero
  assert_single_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && en) |=> !expire_o);
  // R5: service restarts the countdown
  assert_svc_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && svc) |=> cnt_q == $past(reload));
endmodule

// File: rtl/tmo_status.sv
module tmo_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  input  logic irq_en,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (expire) flag_q <= 1'b1;  // set has priority over clear
    else if (clr)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en;

  // R8: expiry raises the flag, even against a clear pulse
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);
  // R8: write-1 clear takes effect on the next edge
  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !expire) |=> !flag_q);
  // R9: flag is sticky
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/dma_req_timeout.sv
module dma_req_timeout #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmo_en,
  input  logic [CNT_W-1:0] tmo_reload,
  input  logic             req_done,
  input  logic             flag_w1c,
  input  logic             irq_en,
  output logic [CNT_W-1:0] count,
  output logic             tmo_flag,
  output logic             tmo_irq
);
  logic expire;

  tmo_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (tmo_en),
    .svc      (req_done),
    .reload   (tmo_reload),
    .cnt_o    (count),
    .expire_o (expire)
  );

  tmo_status u_sts (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire),
    .clr    (flag_w1c),
    .irq_en (irq_en),
    .flag_o (tmo_flag),
    .irq_o  (tmo_irq)
  );

  // R6: a service pulse never lets the flag rise on the following edge
  assert_svc_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_done && !tmo_flag) |=> !tmo_flag);
  // R10: no interrupt without enable
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !tmo_irq);
endmodule

// File: tb/sim_dma_req_timeout.sv
module sim_dma_req_timeout;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmo_en = 1'b0;
  logic [15:0] tmo_reload = 16'd0;
  logic        req_done = 1'b0;
  logic        flag_w1c = 1'b0;
  logic        irq_en = 1'b0;
  logic [15:0] count;
  logic        tmo_flag;
  logic        tmo_irq;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;  // 125 MHz

  dma_req_timeout u0 (
    .clk(clk), .rst_n(rst_n), .tmo_en(tmo_en), .tmo_reload(tmo_reload),
    .req_done(req_done), .flag_w1c(flag_w1c), .irq_en(irq_en),
    .count(count), .tmo_flag(tmo_flag), .tmo_irq(tmo_irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Disable, clear the flag, set the reload value and let the counter settle
  task automatic idle(input int rl);
    tmo_en = 1'b0; tmo_reload = 16'(rl); flag_w1c = 1'b1;
    tick(1);
    flag_w1c = 1'b0;
    tick(1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick(2);
    chk("R1 flag in reset", tmo_flag, 0);
    chk("R1 irq in reset", tmo_irq, 0);
    rst_n = 1'b1; tick(1);
    chk("R1 flag after reset", tmo_flag, 0);
  endtask

  task automatic t_idle();
    tmo_reload = 16'd77; tick(1);
    chk("R2 count follows reload", count, 77);
    tick(3);
    chk("R2 no counting while disabled", count, 77);
  endtask

  task automatic t_countdown();
    idle(5);
    tmo_en = 1'b1;
    tick(1); chk("R3 first step", count, 4);
    tick(3); chk("R3 after four edges", count, 1);
    tick(1); chk("R3 reaches zero", count, 0);
    chk("R3 flag not yet", tmo_flag, 0);
    tick(1); chk("R3 flag after R+1 edges", tmo_flag, 1);
    tick(3); chk("R4 holds at zero", count, 0);
    flag_w1c = 1'b1; tick(1); flag_w1c = 1'b0;
    chk("R8 w1c clears", tmo_flag, 0);
    tick(4); chk("R4 no second expiry", tmo_flag, 0);
  endtask

  task automatic t_service();
    idle(6);
    tmo_en = 1'b1;
    tick(3); chk("R3 mid count", count, 3);
    req_done = 1'b1; tick(1); req_done = 1'b0;
    chk("R5 service reloads", count, 6);
    tick(1); chk("R5 counts again", count, 5);
  endtask

  task automatic t_svc_at_zero();
    idle(3);
    tmo_en = 1'b1;
    tick(3); chk("R6 at zero", count, 0);
    req_done = 1'b1; tick(1); req_done = 1'b0;
    chk("R6 flag suppressed", tmo_flag, 0);
    chk("R6 reloaded", count, 3);
  endtask

  task automatic t_zero_reload();
    idle(0);
    tmo_en = 1'b1;
    tick(1); chk("R7 flag on first edge", tmo_flag, 1);
  endtask

  task automatic t_set_wins();
    idle(2);
    tmo_en = 1'b1;
    tick(2); chk("R8 at zero", count, 0);
    flag_w1c = 1'b1; tick(1); flag_w1c = 1'b0;
    chk("R8 set wins over clear", tmo_flag, 1);
  endtask

  task automatic t_disable();
    // flag is 1 from previous scenario, count is 0
    tmo_en = 1'b0; tick(1);
    chk("R9 disable reloads", count, 2);
    chk("R9 flag kept", tmo_flag, 1);
    tick(3); chk("R9 flag sticky", tmo_flag, 1);
  endtask

  task automatic t_irq();
    irq_en = 1'b0; #1;
    chk("R10 gated off", tmo_irq, 0);
    irq_en = 1'b1; #1;
    chk("R10 gated on", tmo_irq, 1);
    flag_w1c = 1'b1; tick(1); flag_w1c = 1'b0;
    chk("R10 follows flag clear", tmo_irq, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_countdown();
    t_service();
    t_svc_at_zero();
    t_zero_reload();
    t_set_wins();
    t_disable();
    t_irq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule